// File: doc/BRIEF.md
# I2C Block Transfer Sequencer

This block turns one transfer request into the complete series of bus operations that a multi-byte read from, or write to, an I2C target needs. It does not toggle the wires itself. Instead it drives a byte engine below it one command at a time (start condition, stop condition, write one byte, read one byte) and waits for that engine to finish each command before it issues the next one. A request supplies a 7-bit device address, an 8-bit register offset, a byte count and two mode bits: direction, and register-addressed versus legacy. In legacy mode the offset rides inside the address byte and no separate offset byte is sent.

Read data leaves on a byte stream that is qualified by a one-cycle valid. Write data enters on a ready/valid stream. The sequencer splits a write into transactions of at most four data bytes. After each one it polls the target by acknowledge until the target's internal write has finished, and then reads and discards one byte. Completion is signalled by a one-cycle done pulse. An error flag accompanies that pulse when an address or data byte is not acknowledged, or when polling runs out of attempts.

Top module: `i2c_blk_seq`

## Requirements
- R1: The low bit of every address byte is the direction bit (1 = read, 0 = write). A register-addressed read issues START, {dev,0}, the offset byte, then waits at least BUF_CYCLES clock cycles, then issues START and {dev,1}, with no STOP anywhere between the two STARTs.
- R2: In legacy mode the only address phase is START followed by {off[6:0],dir}. No offset byte is sent, for reads or for writes.
- R3: Each read byte appears once on rd_data_o with rd_valid_o high for one cycle, in bus order. Every READ command asks for an acknowledge (eng_rd_ack_o = 1) except the last one, which asks for a NACK and is followed by STOP.
- R4: A NACK on an address or offset byte ends the transfer with a STOP, then done_o is raised with err_o.
- R5: A write is sent in chunks of at most CHUNK_BYTES data bytes. Each chunk is a separate transaction: START, addressing, data, STOP. The offset used by each chunk is the previous chunk's offset plus the previous chunk's length.
- R6: After each chunk's STOP, the block issues START and {dev,1}, and repeats this until the target acknowledges. Every NACKed attempt is followed by a STOP. After POLL_MAX NACKed attempts the transfer ends with done_o and err_o.
- R7: Once a poll is acknowledged, the block reads one byte with NACK and then sends STOP. That byte is not presented on rd_valid_o.
- R8: A NACK on a write data byte ends the transfer with a STOP and done_o with err_o. No further data is taken from the write stream.
- R9: A request with a byte count of zero produces done_o in the cycle after it is accepted, without err_o and without any engine command.
- R10: done_o is a one-cycle pulse, and err_o is never high without done_o. At most one engine command is outstanding at any time: a new eng_cmd_valid_o occurs only after eng_done_i has answered the previous one.
- R11: req_ready_o is high only while idle. The block issues no engine command while idle.
- R12: The engine command codes on eng_cmd_o are START = 0, STOP = 1, WRITE = 2 and READ = 3. eng_byte_o and eng_rd_ack_o are meaningful only while eng_cmd_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request strobe |
| req_ready_o | output | 1 | Sequencer idle; a request is accepted |
| req_write_i | input | 1 | 1 = write transfer, 0 = read transfer |
| req_legacy_i | input | 1 | 1 = offset carried in the address byte |
| req_dev_i | input | 7 | Target device address |
| req_off_i | input | 8 | Register offset |
| req_len_i | input | LEN_W | Byte count |
| wr_data_i | input | 8 | Write stream data |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| rd_data_o | output | 8 | Read stream data |
| rd_valid_o | output | 1 | Read stream valid, one cycle per byte |
| done_o | output | 1 | Transfer finished, one-cycle pulse |
| err_o | output | 1 | Transfer failed, only with done_o |
| eng_cmd_valid_o | output | 1 | Engine command strobe |
| eng_cmd_o | output | 2 | Engine command code |
| eng_byte_o | output | 8 | Byte to transmit for WRITE |
| eng_rd_ack_o | output | 1 | For READ: 1 = send ACK, 0 = send NACK |
| eng_done_i | input | 1 | Engine finished the outstanding command |
| eng_nack_i | input | 1 | With eng_done_i: the written byte was NACKed |
| eng_rd_data_i | input | 8 | With eng_done_i: the byte that was read |

## Verification
The bench models the byte engine and checks the full command trace of each transfer. For a register-addressed read it looks for a STOP slipped in before the repeated START, or a bus-free wait that is too short; either would let another master take the bus or would reset the target's offset pointer. For a six-byte write it checks that the data splits as four then two and that the second chunk addresses offset plus four. A sequencer that did not advance the offset would rewrite the same locations. A poll counter off by one would show up as 99 or 101 poll STARTs, and forwarding the discarded poll byte would add a spurious read beat. It also covers a data-byte NACK that must stop consumption of the write stream, and a zero-length request that must not touch the bus.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;

  typedef enum logic [1:0] {
    ECMD_START = 2'd0,
    ECMD_STOP  = 2'd1,
    ECMD_WRITE = 2'd2,
    ECMD_READ  = 2'd3
  } eng_cmd_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_FIN,
    S_ABORT,
    R_START,
    R_ADDR,
    R_OFF,
    R_BUF,
    R_RSTART,
    R_DADDR,
    R_DATA,
    R_STOP,
    W_START,
    W_ADDR,
    W_OFF,
    W_DATA,
    W_STOP,
    P_START,
    P_ADDR,
    P_NSTOP,
    P_READ,
    P_RSTOP
  } seq_state_e;

endpackage

// File: rtl/i2c_blk_addr_gen.sv
module i2c_blk_addr_gen (
  input  logic [6:0] dev_i,
  input  logic [6:0] off_lo_i,
  input  logic       legacy_i,
  output logic [7:0] first_rd_o,
  output logic [7:0] first_wr_o,
  output logic [7:0] dev_rd_o
);
  // legacy targets take the offset in place of the device address
  assign first_rd_o = legacy_i ? {off_lo_i, 1'b1} : {dev_i, 1'b0};
  assign first_wr_o = legacy_i ? {off_lo_i, 1'b0} : {dev_i, 1'b0};
  assign dev_rd_o   = {dev_i, 1'b1};
endmodule

// File: rtl/i2c_blk_delay.sv
module i2c_blk_delay #(
  parameter int unsigned CYCLES = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/i2c_blk_poll_ctr.sv
module i2c_blk_poll_ctr #(
  parameter int unsigned MAX = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // current attempt is the final one allowed
  assign last_o = (cnt_q == CNT_W'(MAX - 1));
endmodule

// File: rtl/i2c_blk_seq.sv
module i2c_blk_seq
  import i2c_blk_pkg::*;
#(
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned CHUNK_BYTES = 4,
  parameter int unsigned POLL_MAX    = 100,
  parameter int unsigned BUF_CYCLES  = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_legacy_i,
  input  logic [6:0]       req_dev_i,
  input  logic [7:0]       req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic             eng_cmd_valid_o,
  output logic [1:0]       eng_cmd_o,
  output logic [7:0]       eng_byte_o,
  output logic             eng_rd_ack_o,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic [7:0]       eng_rd_data_i
);
  localparam int unsigned CHUNK_W = $clog2(CHUNK_BYTES + 1);

  seq_state_e         state_q;
  logic               issued_q;
  logic [6:0]         dev_q;
  logic [7:0]         off_q;
  logic               legacy_q;
  logic [LEN_W-1:0]   rem_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic               err_q;
  logic               rd_valid_q;
  logic [7:0]         rd_data_q;

  logic               step;
  logic               is_cmd;
  eng_cmd_e           cmd_c;
  logic [7:0]         first_rd, first_wr, dev_rd;
  logic               buf_start, buf_done;
  logic               poll_clr, poll_inc, poll_last;

  i2c_blk_addr_gen u_addr (
    .dev_i     (dev_q),
    .off_lo_i  (off_q[6:0]),
    .legacy_i  (legacy_q),
    .first_rd_o(first_rd),
    .first_wr_o(first_wr),
    .dev_rd_o  (dev_rd)
  );

  i2c_blk_delay #(.CYCLES(BUF_CYCLES)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (buf_start),
    .expired_o(buf_done)
  );

  i2c_blk_poll_ctr #(.MAX(POLL_MAX)) u_poll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (poll_clr),
    .inc_i (poll_inc),
    .last_o(poll_last)
  );

  assign step      = issued_q && eng_done_i;
  assign buf_start = step && (state_q == R_OFF) && !eng_nack_i;
  assign poll_clr  = step && (state_q == W_STOP);
  assign poll_inc  = step && (state_q == P_NSTOP);

  always_comb begin
    is_cmd     = 1'b1;
    cmd_c      = ECMD_WRITE;
    eng_byte_o = 8'h00;
    unique case (state_q)
      R_START, R_RSTART, W_START, P_START:         cmd_c = ECMD_START;
      R_STOP, W_STOP, P_NSTOP, P_RSTOP, S_ABORT:   cmd_c = ECMD_STOP;
      R_DATA, P_READ:                              cmd_c = ECMD_READ;
      R_ADDR:  eng_byte_o = first_rd;
      W_ADDR:  eng_byte_o = first_wr;
      R_OFF,
      W_OFF:   eng_byte_o = off_q;
      R_DADDR,
      P_ADDR:  eng_byte_o = dev_rd;
      W_DATA:  eng_byte_o = wr_data_i;
      default: is_cmd = 1'b0;
    endcase
  end

  assign eng_cmd_o       = cmd_c;
  assign eng_cmd_valid_o = is_cmd && !issued_q && ((state_q != W_DATA) || wr_valid_i);
  assign eng_rd_ack_o    = (state_q == R_DATA) && (rem_q != LEN_W'(1));
  assign wr_ready_o      = (state_q == W_DATA) && !issued_q;
  assign req_ready_o     = (state_q == S_IDLE);
  assign done_o          = (state_q == S_FIN);
  assign err_o           = (state_q == S_FIN) && err_q;
  assign rd_valid_o      = rd_valid_q;
  assign rd_data_o       = rd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      issued_q   <= 1'b0;
      dev_q      <= '0;
      off_q      <= '0;
      legacy_q   <= 1'b0;
      rem_q      <= '0;
      chunk_q    <= '0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      if (eng_cmd_valid_o) issued_q <= 1'b1;
      if (step)            issued_q <= 1'b0;

      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          dev_q    <= req_dev_i;
          off_q    <= req_off_i;
          legacy_q <= req_legacy_i;
          rem_q    <= req_len_i;
          err_q    <= 1'b0;
          if (req_len_i == '0)  state_q <= S_FIN;
          else if (req_write_i) state_q <= W_START;
          else                  state_q <= R_START;
        end
        S_FIN: state_q <= S_IDLE;
        S_ABORT: if (step) begin
          err_q   <= 1'b1;
          state_q <= S_FIN;
        end
        R_START:  if (step) state_q <= R_ADDR;
        R_ADDR: if (step) begin
          if (eng_nack_i)    state_q <= S_ABORT;
          else if (legacy_q) state_q <= R_DATA;
          else               state_q <= R_OFF;
        end
        R_OFF:    if (step) state_q <= eng_nack_i ? S_ABORT : R_BUF;
        R_BUF:    if (buf_done) state_q <= R_RSTART;
        R_RSTART: if (step) state_q <= R_DADDR;
        R_DADDR:  if (step) state_q <= eng_nack_i ? S_ABORT : R_DATA;
        R_DATA: if (step) begin
          rd_valid_q <= 1'b1;
          rd_data_q  <= eng_rd_data_i;
          rem_q      <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) state_q <= R_STOP;
        end
        R_STOP: if (step) state_q <= S_FIN;
        W_START: if (step) begin
          chunk_q <= (rem_q >= LEN_W'(CHUNK_BYTES)) ? CHUNK_W'(CHUNK_BYTES) : CHUNK_W'(rem_q);
          state_q <= W_ADDR;
        end
        W_ADDR: if (step) begin
          if (eng_nack_i)    state_q <= S_ABORT;
          else if (legacy_q) state_q <= W_DATA;
          else               state_q <= W_OFF;
        end
        W_OFF: if (step) state_q <= eng_nack_i ? S_ABORT : W_DATA;
        W_DATA: if (step) begin
          if (eng_nack_i) state_q <= S_ABORT;
          else begin
            rem_q   <= rem_q - 1'b1;
            off_q   <= off_q + 1'b1;
            chunk_q <= chunk_q - 1'b1;
            if (chunk_q == CHUNK_W'(1)) state_q <= W_STOP;
          end
        end
        W_STOP:  if (step) state_q <= P_START;
        P_START: if (step) state_q <= P_ADDR;
        P_ADDR:  if (step) state_q <= eng_nack_i ? P_NSTOP : P_READ;
        P_NSTOP: if (step) begin
          if (poll_last) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            state_q <= P_START;
          end
        end
        P_READ:  if (step) state_q <= P_RSTOP;
        P_RSTOP: if (step) state_q <= (rem_q == '0) ? S_FIN : W_START;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_blk_seq_chk.sv
module i2c_blk_seq_chk
  import i2c_blk_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       wr_valid_i,
  input logic       wr_ready_o,
  input logic       rd_valid_o,
  input logic       done_o,
  input logic       err_o,
  input logic       eng_cmd_valid_o,
  input logic [1:0] eng_cmd_o,
  input logic       eng_done_i
);
  logic       pend_q;
  logic [7:0] data_cnt_q;
  logic       wr_hs;

  assign wr_hs = wr_valid_i && wr_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      data_cnt_q <= '0;
    end else begin
      if (eng_cmd_valid_o)  pend_q <= 1'b1;
      else if (eng_done_i)  pend_q <= 1'b0;
      if (eng_cmd_valid_o && eng_cmd_o == ECMD_STOP) data_cnt_q <= '0;
      else if (wr_hs)                                data_cnt_q <= data_cnt_q + 1'b1;
    end
  end

  AST_ONE_CMD_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cmd_valid_o |-> !pend_q); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
  AST_CHUNK_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_cnt_q <= 8'(CHUNK_BYTES)); // R5
  AST_WR_HS_SENDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hs |-> (eng_cmd_valid_o && eng_cmd_o == ECMD_WRITE)); // R12
  AST_IDLE_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !eng_cmd_valid_o); // R11
  AST_RD_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !req_ready_o); // R3
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !eng_cmd_valid_o); // R9
endmodule

bind i2c_blk_seq i2c_blk_seq_chk #(.CHUNK_BYTES(CHUNK_BYTES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .wr_valid_i     (wr_valid_i),
  .wr_ready_o     (wr_ready_o),
  .rd_valid_o     (rd_valid_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .eng_cmd_valid_o(eng_cmd_valid_o),
  .eng_cmd_o      (eng_cmd_o),
  .eng_done_i     (eng_done_i)
);

// File: tb/i2c_blk_seq_tb.sv
module i2c_blk_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUF        = 60;
  localparam int PMAX       = 100;
  localparam int ENG_LAT    = 2;
  localparam logic [6:0] DEV = 7'h50;
  localparam int C_START = 0, C_STOP = 1, C_WRITE = 2, C_READ = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0, req_write_i = 1'b0, req_legacy_i = 1'b0;
  logic [6:0] req_dev_i = DEV;
  logic [7:0] req_off_i = '0;
  logic [7:0] req_len_i = '0;
  logic [7:0] wr_data_i;
  logic       wr_valid_i;
  logic       req_ready_o, wr_ready_o, rd_valid_o, done_o, err_o;
  logic [7:0] rd_data_o, eng_byte_o;
  logic       eng_cmd_valid_o, eng_rd_ack_o;
  logic [1:0] eng_cmd_o;
  logic       eng_done_i = 1'b0, eng_nack_i = 1'b0;
  logic [7:0] eng_rd_data_i = '0;

  i2c_blk_seq #(.LEN_W(8), .CHUNK_BYTES(4), .POLL_MAX(PMAX), .BUF_CYCLES(BUF)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_legacy_i(req_legacy_i),
    .req_dev_i(req_dev_i), .req_off_i(req_off_i), .req_len_i(req_len_i),
    .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .done_o(done_o), .err_o(err_o),
    .eng_cmd_valid_o(eng_cmd_valid_o), .eng_cmd_o(eng_cmd_o),
    .eng_byte_o(eng_byte_o), .eng_rd_ack_o(eng_rd_ack_o),
    .eng_done_i(eng_done_i), .eng_nack_i(eng_nack_i), .eng_rd_data_i(eng_rd_data_i)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // write stream feeder
  logic [7:0] wr_mem [256];
  int wr_cnt = 0, wr_n = 0;
  assign wr_valid_i = (wr_cnt < wr_n);
  assign wr_data_i  = wr_mem[wr_cnt[7:0]];
  always @(posedge clk_i) if (wr_valid_i && wr_ready_o) wr_cnt <= wr_cnt + 1;

  // byte engine model and trace log
  int         n_log = 0, n_rd = 0, rd_cnt = 0, tmr = 0;
  int         log_cmd [1024];
  logic [7:0] log_byte [1024];
  logic       log_ack [1024];
  int         log_cyc [1024];
  logic [7:0] rd_got [256];
  logic       nack_en = 1'b0;
  logic [7:0] nack_byte = '0;
  int         nack_left = 0;
  logic       pn = 1'b0;
  logic [7:0] pd = '0;

  always @(negedge clk_i) begin
    eng_done_i = 1'b0;
    eng_nack_i = 1'b0;
    if (tmr > 0) begin
      tmr--;
      if (tmr == 0) begin
        eng_done_i    = 1'b1;
        eng_nack_i    = pn;
        eng_rd_data_i = pd;
      end
    end
    if (eng_cmd_valid_o) begin
      log_cmd[n_log]  = int'(eng_cmd_o);
      log_byte[n_log] = eng_byte_o;
      log_ack[n_log]  = eng_rd_ack_o;
      log_cyc[n_log]  = cyc;
      n_log++;
      tmr = ENG_LAT;
      pn  = 1'b0;
      pd  = 8'h00;
      if (int'(eng_cmd_o) == C_WRITE && nack_en && eng_byte_o == nack_byte && nack_left > 0) begin
        pn = 1'b1;
        nack_left--;
      end
      if (int'(eng_cmd_o) == C_READ) begin
        pd = 8'(8'h30 + rd_cnt);
        rd_cnt++;
      end
    end
    if (rd_valid_o) begin
      rd_got[n_rd[7:0]] = rd_data_o;
      n_rd++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_op(input string req, input int base, input int idx, input int cmd, input int b);
    chk(log_cmd[base+idx] == cmd, req, log_cmd[base+idx], cmd);
    if (cmd == C_WRITE) chk(int'(log_byte[base+idx]) == b, req, int'(log_byte[base+idx]), b);
    if (cmd == C_READ)  chk(int'(log_ack[base+idx]) == b, req, int'(log_ack[base+idx]), b);
  endtask

  task automatic run(input bit wr, input bit leg, input logic [7:0] off, input int len,
                     output bit err, output int waited);
    @(negedge clk_i);
    req_write_i  = wr;
    req_legacy_i = leg;
    req_off_i    = off;
    req_len_i    = 8'(len);
    req_valid_i  = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    waited = 0;
    while (!done_o) begin
      @(negedge clk_i);
      waited++;
    end
    err = err_o;
    @(negedge clk_i);
    chk(!done_o, "R10 done pulse width", int'(done_o), 0);
  endtask

  task automatic t_reset;
    chk(req_ready_o == 1'b1, "R11 ready after reset", int'(req_ready_o), 1);
    chk(!done_o && !err_o, "R10 no done after reset", int'(done_o), 0);
    chk(!eng_cmd_valid_o, "R11 no command after reset", int'(eng_cmd_valid_o), 0);
  endtask

  task automatic t_reg_read;
    int b = n_log, r = n_rd, r0 = rd_cnt, w;
    bit e;
    run(1'b0, 1'b0, 8'h10, 3, e, w);
    chk(!e, "R1 reg read no error", int'(e), 0);
    chk(n_log - b == 9, "R1 reg read op count", n_log - b, 9);
    exp_op("R1 start", b, 0, C_START, 0);
    exp_op("R1 dev write addr", b, 1, C_WRITE, 8'hA0);
    exp_op("R1 offset", b, 2, C_WRITE, 8'h10);
    exp_op("R1 repeated start", b, 3, C_START, 0);
    exp_op("R1 dev read addr", b, 4, C_WRITE, 8'hA1);
    exp_op("R3 ack byte0", b, 5, C_READ, 1);
    exp_op("R3 ack byte1", b, 6, C_READ, 1);
    exp_op("R3 nack last", b, 7, C_READ, 0);
    exp_op("R3 stop", b, 8, C_STOP, 0);
    chk(log_cyc[b+3] - log_cyc[b+2] >= BUF, "R1 bus-free wait", log_cyc[b+3] - log_cyc[b+2], BUF);
    chk(n_rd - r == 3, "R3 read beat count", n_rd - r, 3);
    for (int k = 0; k < 3; k++)
      chk(rd_got[8'(r + k)] == 8'(8'h30 + r0 + k), "R3 read data order",
          int'(rd_got[8'(r + k)]), 8'h30 + r0 + k);
  endtask

  task automatic t_legacy_read;
    int b = n_log, r = n_rd, w;
    bit e;
    run(1'b0, 1'b1, 8'h25, 1, e, w);
    chk(!e && n_log - b == 4, "R2 legacy read op count", n_log - b, 4);
    exp_op("R2 start", b, 0, C_START, 0);
    exp_op("R2 legacy address byte", b, 1, C_WRITE, 8'h4B);
    exp_op("R3 single byte nack", b, 2, C_READ, 0);
    exp_op("R3 stop", b, 3, C_STOP, 0);
    chk(n_rd - r == 1, "R3 legacy one beat", n_rd - r, 1);
  endtask

  task automatic t_read_off_nack;
    int b = n_log, r = n_rd, w;
    bit e;
    nack_en = 1'b1; nack_byte = 8'h33; nack_left = 1;
    run(1'b0, 1'b0, 8'h33, 2, e, w);
    nack_en = 1'b0;
    chk(e, "R4 offset nack error", int'(e), 1);
    chk(n_log - b == 4, "R4 abort op count", n_log - b, 4);
    exp_op("R4 stop after nack", b, 3, C_STOP, 0);
    chk(n_rd == r, "R4 no read beats", n_rd - r, 0);
  endtask

  task automatic t_write_chunks;
    int b = n_log, r = n_rd, w;
    bit e;
    for (int k = 0; k < 6; k++) wr_mem[8'(wr_cnt + k)] = 8'(8'h11 + k);
    wr_n = wr_cnt + 6;
    run(1'b1, 1'b0, 8'h20, 6, e, w);
    chk(!e && n_log - b == 22, "R5 write op count", n_log - b, 22);
    exp_op("R5 chunk1 addr", b, 1, C_WRITE, 8'hA0);
    exp_op("R5 chunk1 offset", b, 2, C_WRITE, 8'h20);
    for (int k = 0; k < 4; k++) exp_op("R5 chunk1 data", b, 3 + k, C_WRITE, 8'h11 + k);
    exp_op("R5 chunk1 stop", b, 7, C_STOP, 0);
    exp_op("R6 poll start", b, 8, C_START, 0);
    exp_op("R6 poll addr", b, 9, C_WRITE, 8'hA1);
    exp_op("R7 discard read nack", b, 10, C_READ, 0);
    exp_op("R7 stop after discard", b, 11, C_STOP, 0);
    exp_op("R5 chunk2 offset", b, 14, C_WRITE, 8'h24);
    exp_op("R5 chunk2 data", b, 16, C_WRITE, 8'h16);
    exp_op("R5 chunk2 stop", b, 17, C_STOP, 0);
    chk(n_rd == r, "R7 discarded byte not streamed", n_rd - r, 0);
    chk(wr_cnt == wr_n, "R5 all write data taken", wr_cnt, wr_n);
  endtask

  task automatic t_poll_retry;
    int b = n_log, w;
    bit e;
    wr_mem[8'(wr_cnt)] = 8'h21; wr_n = wr_cnt + 1;
    nack_en = 1'b1; nack_byte = 8'hA1; nack_left = 2;
    run(1'b1, 1'b0, 8'h40, 1, e, w);
    nack_en = 1'b0;
    chk(!e && n_log - b == 15, "R6 poll retry op count", n_log - b, 15);
    exp_op("R6 stop after failed poll", b, 7, C_STOP, 0);
    exp_op("R6 second poll addr", b, 9, C_WRITE, 8'hA1);
    exp_op("R7 read after acked poll", b, 13, C_READ, 0);
  endtask

  task automatic t_poll_timeout;
    int b = n_log, starts = 0, w;
    bit e;
    wr_mem[8'(wr_cnt)] = 8'h22; wr_n = wr_cnt + 1;
    nack_en = 1'b1; nack_byte = 8'hA1; nack_left = 1000;
    run(1'b1, 1'b0, 8'h50, 1, e, w);
    nack_en = 1'b0;
    for (int k = b; k < n_log; k++) if (log_cmd[k] == C_START) starts++;
    chk(e, "R6 poll timeout error", int'(e), 1);
    chk(starts == 1 + PMAX, "R6 poll attempt count", starts, 1 + PMAX);
    chk(log_cmd[n_log-1] == C_STOP, "R6 ends with stop", log_cmd[n_log-1], C_STOP);
  endtask

  task automatic t_data_nack;
    int b = n_log, c0 = wr_cnt, w;
    bit e;
    for (int k = 0; k < 3; k++) wr_mem[8'(wr_cnt + k)] = 8'(8'h5A + k);
    wr_n = wr_cnt + 3;
    nack_en = 1'b1; nack_byte = 8'h5A; nack_left = 1;
    run(1'b1, 1'b0, 8'h60, 3, e, w);
    nack_en = 1'b0;
    chk(e, "R8 data nack error", int'(e), 1);
    chk(n_log - b == 5, "R8 abort op count", n_log - b, 5);
    exp_op("R8 stop after data nack", b, 4, C_STOP, 0);
    chk(wr_cnt - c0 == 1, "R8 no further data taken", wr_cnt - c0, 1);
    wr_n = wr_cnt;
  endtask

  task automatic t_zero_len;
    int b = n_log, w;
    bit e;
    run(1'b1, 1'b0, 8'h00, 0, e, w);
    chk(!e && w == 0, "R9 zero length immediate done", w, 0);
    chk(n_log == b, "R9 no engine commands", n_log - b, 0);
  endtask

  task automatic t_legacy_write;
    int b = n_log, w;
    bit e;
    wr_mem[8'(wr_cnt)] = 8'h31; wr_mem[8'(wr_cnt + 1)] = 8'h32; wr_n = wr_cnt + 2;
    run(1'b1, 1'b1, 8'h05, 2, e, w);
    chk(!e && n_log - b == 9, "R2 legacy write op count", n_log - b, 9);
    exp_op("R2 legacy write address", b, 1, C_WRITE, 8'h0A);
    exp_op("R2 data follows address", b, 2, C_WRITE, 8'h31);
    exp_op("R6 legacy poll addr", b, 6, C_WRITE, 8'hA1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reg_read();
    t_legacy_read();
    t_read_off_nack();
    t_write_chunks();
    t_poll_retry();
    t_poll_timeout();
    t_data_nack();
    t_zero_len();
    t_legacy_write();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule